// File: doc/BRIEF.md
# I2C Slave Front End with 16-bit Register Bank

This block is the serial-bus side of a monitoring device. It watches SCL and SDA from open-drain pads, which it first passes through two-flop synchronisers into its own, faster system clock. It finds START and STOP conditions, compares the first byte of each transfer with its device address and answers with ACK when the address is its own. It keeps a small bank of 16-bit registers that the bus master reads and writes.

The device address is a fixed three-bit prefix followed by four bits taken from strap inputs. A write carries a register pointer byte and then one 16-bit word, sent as two bytes with the high byte first. A read returns the register that the last written pointer selects. The read sends the high byte first and carries on for as long as the master acknowledges. The block drives SDA only by pulling it low through an output-enable. It never stretches the clock.

Top module: `i2c_mon_slave`

## Requirements
- R1: A START is a falling SDA while SCL is high, and a STOP is a rising SDA while SCL is high. A STOP in the middle of a byte returns the slave to idle.
- R2: Until it sees a START, the slave ignores all bus activity. Bytes clocked without a START get no ACK.
- R3: The first byte after START is the identification byte. Bits 7..1 must equal 1,0,0,strap[3],strap[2],strap[1],strap[0], and bit 0 is the direction (0 = write, 1 = read). On a match the slave pulls SDA low in the ninth clock. On any other value it gives no ACK, here or on any later byte, until the next START.
- R4: A write is made of the identification byte, a pointer byte, a high data byte and a low data byte, each one acknowledged. The register takes the 16-bit value {high, low} only once the ACK clock of the low byte has ended.
- R5: A STOP or repeated START that follows only the high data byte leaves the register unchanged.
- R6: The pointer byte selects register index (pointer mod NREG), that is, its low log2(NREG) bits.
- R7: A read returns the register selected by the last written pointer, MSB first, high byte then low byte. After each byte that the master acknowledges, the other byte follows, so a third byte repeats the high byte.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released until the next START.
- R9: SDA is released after reset. The slave starts pulling SDA low only while SCL is low.
- R10: A START that arrives within BOOT_CYCLES clocks after reset is ignored.
- R11: A repeated START in the middle of a transfer starts address matching again.
- R12: A byte written after the low data byte is not acknowledged and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level (wired bus value) |
| strap_i | input | 4 | Low four bits of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
All 128 seven-bit addresses are swept with the write direction. This shows that the prefix and every strap bit take part in the match. Several strap settings are then tried so that the strap bits are known to be live and not fixed. Every register is written with an arithmetic pattern and read back, which separates index decoding from byte order. Pointers with high bits set show that the pointer wraps. The abort cases (STOP or repeated START after the high byte, and an extra byte after the low byte) show whether the update is tied to the low byte's ACK. A three-byte read with master ACKs and a read ended by NACK show the high/low alternation and the release of SDA.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam logic [2:0] ID_PREFIX = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK,
        ST_WAIT
    } st_e;

    typedef enum logic [2:0] {
        K_ADDR,
        K_PTR,
        K_WHI,
        K_WLO,
        K_RHI,
        K_RLO
    } kind_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    function automatic logic id_match(input logic [BYTE_W-1:0] b, input logic [3:0] strap);
        return b[BYTE_W-1:1] == {ID_PREFIX, strap};
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond
    import i2cs_pkg::*;
#(
    parameter int BOOT_CYCLES = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev,
    output logic    boot_busy
);
    localparam int BW = $clog2(BOOT_CYCLES + 1);
    localparam logic [BW-1:0] BOOT_END = BW'(BOOT_CYCLES);

    logic          scl_p, sda_p;
    logic [BW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
            bcnt  <= '0;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
            if (boot_busy) bcnt <= bcnt + 1'b1;
        end
    end

    assign boot_busy = (bcnt != BOOT_END);

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.rise  = ~scl_p & scl_s;
        ev.fall  = scl_p & ~scl_s;
        ev.start = scl_p & scl_s & sda_p & ~sda_s & ~boot_busy;
        ev.stop  = scl_p & scl_s & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank
    import i2cs_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

    // R4: a completed write is a single-cycle strobe
    assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);
endmodule

// File: rtl/i2cs_proto.sv
module i2cs_proto
    import i2cs_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              boot_busy,
    input  logic [3:0]        strap,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  ptr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              sda_oe
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    st_e               st;
    kind_e             kind;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] hold;
    logic              mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            kind    <= K_ADDR;
            cnt     <= '0;
            shreg   <= '0;
            hold    <= '0;
            mack    <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                st     <= ST_RX;
                kind   <= K_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.rise) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.fall && cnt == LAST_BIT) begin
                            cnt <= '0;
                            if (kind == K_ADDR && !id_match(shreg, strap)) begin
                                st <= ST_WAIT;
                            end else begin
                                st     <= ST_RXACK;
                                sda_oe <= 1'b1;
                            end
                        end
                    end
                    ST_RXACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            case (kind)
                                K_ADDR: begin
                                    if (shreg[0]) begin
                                        st     <= ST_TX;
                                        kind   <= K_RHI;
                                        sda_oe <= ~rd_data[DATA_W-1];
                                        shreg  <= {rd_data[DATA_W-2:BYTE_W], 1'b0};
                                    end else begin
                                        st   <= ST_RX;
                                        kind <= K_PTR;
                                    end
                                end
                                K_PTR: begin
                                    ptr  <= shreg[IDX_W-1:0];
                                    st   <= ST_RX;
                                    kind <= K_WHI;
                                end
                                K_WHI: begin
                                    hold <= shreg;
                                    st   <= ST_RX;
                                    kind <= K_WLO;
                                end
                                default: begin
                                    wr_en   <= 1'b1;
                                    wr_data <= {hold, shreg};
                                    st      <= ST_WAIT;
                                end
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (ev.rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.fall) begin
                            if (cnt == LAST_BIT) begin
                                cnt    <= '0;
                                sda_oe <= 1'b0;
                                st     <= ST_TXACK;
                            end else begin
                                sda_oe <= ~shreg[BYTE_W-1];
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (ev.rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (!mack) begin
                                st <= ST_WAIT;
                            end else if (kind == K_RHI) begin
                                st     <= ST_TX;
                                kind   <= K_RLO;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                shreg  <= {rd_data[BYTE_W-2:0], 1'b0};
                            end else begin
                                st     <= ST_TX;
                                kind   <= K_RHI;
                                sda_oe <= ~rd_data[DATA_W-1];
                                shreg  <= {rd_data[DATA_W-2:BYTE_W], 1'b0};
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: the pull-down only starts while the synchronised SCL is low
    assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    // R10: no transfer can begin while the boot window is open
    assert_boot_idle_R10: assert property (@(posedge clk) disable iff (rst)
        boot_busy |-> st == ST_IDLE);

    // R11: any START restarts matching with SDA released
    assert_start_restart_R11: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (st == ST_RX && kind == K_ADDR && !sda_oe && cnt == 4'd0));

    // R1: STOP returns to idle
    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (st == ST_IDLE && !sda_oe));

    // R4: register update follows the low byte's ACK clock
    assert_wr_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(st) == ST_RXACK && $past(ev.fall)));

    // R8: once waiting for START, SDA stays released
    assert_wait_release_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && $past(st) == ST_WAIT) |-> !sda_oe);
endmodule

// File: rtl/i2c_mon_slave.sv
module i2c_mon_slave
    import i2cs_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int BOOT_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [3:0] strap_i,
    output logic       sda_oe_o
);
    localparam int IDX_W = $clog2(NREG);

    logic [1:0]        pads_s;
    bus_ev_t           ev;
    logic              boot_busy;
    logic [IDX_W-1:0]  ptr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (pads_s)
    );

    i2cs_cond #(.BOOT_CYCLES(BOOT_CYCLES)) u_cond (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (pads_s[1]),
        .sda_s     (pads_s[0]),
        .ev        (ev),
        .boot_busy (boot_busy)
    );

    i2cs_proto #(.IDX_W(IDX_W)) u_proto (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .boot_busy (boot_busy),
        .strap     (strap_i),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe_o)
    );

    i2cs_regbank #(.NREG(NREG), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (ptr),
        .wr_data (wr_data),
        .rd_idx  (ptr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/test_i2c_mon_slave.sv
module test_i2c_mon_slave;

    localparam int Q    = 10;
    localparam int NREG = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [3:0] strap = 4'b1010;
    logic       sda_oe;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model [NREG];

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_mon_slave i_i2c_mon_slave (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .sda_oe_o (sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = ~sda_line;
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d, output logic oe_seen);
        oe_seen = 1'b0;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            d = {d[6:0], sda_line};
            oe_seen = oe_seen | sda_oe;
            m_scl = 1'b0; tick(Q);
        end
        m_sda = ~give_ack; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] id_byte(input logic rd);
        return {3'b100, strap, rd};
    endfunction

    task automatic write_reg(input logic [7:0] ptr, input logic [15:0] v, output logic [3:0] acks);
        bus_start();
        send_byte(id_byte(1'b0), acks[3]);
        send_byte(ptr, acks[2]);
        send_byte(v[15:8], acks[1]);
        send_byte(v[7:0], acks[0]);
        bus_stop();
    endtask

    task automatic read_reg(input logic [7:0] ptr, output logic [15:0] v);
        logic a;
        logic oe;
        bus_start();
        send_byte(id_byte(1'b0), a);
        send_byte(ptr, a);
        bus_start();
        send_byte(id_byte(1'b1), a);
        read_byte(1'b1, v[15:8], oe);
        read_byte(1'b0, v[7:0], oe);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic        a;
        logic [3:0]  acks;
        logic [15:0] v;
        logic [7:0]  b0, b1, b2;
        logic        oe;

        tick(4);
        rst = 1'b0;
        check(sda_oe == 1'b0, "R9 reset release", 32'(sda_oe), 0);

        // R10: START during boot window is ignored
        bus_start();
        send_byte(id_byte(1'b0), a);
        check(a == 1'b0, "R10 boot start", 32'(a), 0);
        bus_stop();
        tick(100);

        // R3: sweep every address with write direction
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            send_byte({ad[6:0], 1'b0}, a);
            bus_stop();
            check(a == (ad[6:0] == {3'b100, strap}), "R3 address sweep",
                  32'(a), 32'(ad[6:0] == {3'b100, strap}));
        end

        // R3: strap bits are live
        for (int s = 0; s < 16; s += 5) begin
            strap = 4'(s);
            bus_start();
            send_byte(id_byte(1'b0), a);
            bus_stop();
            check(a == 1'b1, "R3 strap match", 32'(a), 1);
            bus_start();
            send_byte(id_byte(1'b0) ^ 8'h02, a);
            bus_stop();
            check(a == 1'b0, "R3 strap mismatch", 32'(a), 0);
        end
        strap = 4'b1010;

        // R4 / R7: write every register, then read back
        for (int i = 0; i < NREG; i++) begin
            model[i] = 16'(i * 16'h3D1B) ^ 16'hC6A5;
            write_reg(8'(i), model[i], acks);
            check(acks == 4'hF, "R4 write acks", 32'(acks), 32'hF);
        end
        for (int i = NREG - 1; i >= 0; i--) begin
            read_reg(8'(i), v);
            check(v == model[i], "R7 read back", 32'(v), 32'(model[i]));
        end

        // R6: pointer wraps modulo NREG
        model[2] = 16'h8001;
        write_reg(8'h0A, model[2], acks);
        read_reg(8'h02, v);
        check(v == model[2], "R6 pointer wrap write", 32'(v), 32'(model[2]));
        read_reg(8'hF5, v);
        check(v == model[5], "R6 pointer wrap read", 32'(v), 32'(model[5]));

        // R5: STOP after only the high byte
        bus_start();
        send_byte(id_byte(1'b0), a);
        send_byte(8'h01, a);
        send_byte(8'h77, a);
        check(a == 1'b1, "R5 high byte ack", 32'(a), 1);
        bus_stop();
        read_reg(8'h01, v);
        check(v == model[1], "R5 stop after high byte", 32'(v), 32'(model[1]));

        // R11 / R5: repeated START after high byte, wrong id, then good id
        bus_start();
        send_byte(id_byte(1'b0), a);
        send_byte(8'h03, a);
        send_byte(8'hEE, a);
        bus_start();
        send_byte(id_byte(1'b0) ^ 8'h80, a);
        check(a == 1'b0, "R11 restart wrong id", 32'(a), 0);
        bus_start();
        send_byte(id_byte(1'b1), a);
        check(a == 1'b1, "R11 restart good id", 32'(a), 1);
        read_byte(1'b1, b0, oe);
        read_byte(1'b0, b1, oe);
        bus_stop();
        check({b0, b1} == model[3], "R5 restart after high byte", 32'({b0, b1}), 32'(model[3]));

        // R7: continued read alternates high, low, high
        read_reg(8'h04, v);
        bus_start();
        send_byte(id_byte(1'b1), a);
        read_byte(1'b1, b0, oe);
        read_byte(1'b1, b1, oe);
        read_byte(1'b0, b2, oe);
        bus_stop();
        check({b0, b1, b2} == {model[4], model[4][15:8]}, "R7 three byte read",
              32'({b0, b1, b2}), 32'({model[4], model[4][15:8]}));

        // R8: after NACK the slave stays released
        model[0] = 16'h0000;
        write_reg(8'h00, model[0], acks);
        bus_start();
        send_byte(id_byte(1'b1), a);
        read_byte(1'b0, b0, oe);
        check(b0 == 8'h00, "R8 byte before nack", 32'(b0), 0);
        read_byte(1'b0, b1, oe);
        bus_stop();
        check(b1 == 8'hFF && !oe, "R8 released after nack", 32'({oe, b1}), 32'h0FF);

        // R3: after mismatch later bytes get no ACK
        bus_start();
        send_byte(8'h90, a);
        send_byte(id_byte(1'b0), a);
        bus_stop();
        check(a == 1'b0, "R3 silent after mismatch", 32'(a), 0);

        // R2: bytes without START are ignored
        send_byte(id_byte(1'b0), a);
        check(a == 1'b0, "R2 no start", 32'(a), 0);
        bus_stop();

        // R1: STOP in mid byte returns to idle
        bus_start();
        put_bit(1'b1);
        put_bit(1'b0);
        put_bit(1'b0);
        bus_stop();
        m_scl = 1'b0; tick(Q);
        send_byte(id_byte(1'b0), a);
        check(a == 1'b0, "R1 stop mid byte", 32'(a), 0);
        bus_stop();

        // R12: extra byte after the low byte
        model[6] = 16'h5AA5;
        bus_start();
        send_byte(id_byte(1'b0), a);
        send_byte(8'h06, a);
        send_byte(8'h5A, a);
        send_byte(8'hA5, a);
        send_byte(8'h33, a);
        bus_stop();
        check(a == 1'b0, "R12 extra byte nack", 32'(a), 0);
        read_reg(8'h06, v);
        check(v == model[6], "R12 register kept", 32'(v), 32'(model[6]));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule